// File: doc/BRIEF.md
# Floating-Point Significand Rounding Unit

This block is the final rounding stage of a single-precision arithmetic datapath. An upstream adder, multiplier or converter passes it the result's sign, its biased exponent and its 24-bit significand with the hidden bit written out. It also passes three low-order bits that were kept below the last significand position: a guard bit, a round bit and a sticky bit. The sticky bit is the OR of everything shifted out below the round bit. A 2-bit select picks one of four rounding directions. The block is purely combinational, so its outputs follow its inputs within the same cycle.

The block decides whether the magnitude is bumped by one unit in the last place and applies that increment. If the increment carries out of the significand, the block shifts the significand right and raises the exponent by one. If that pushes the exponent to the all-ones code, the result becomes infinity and an overflow flag is raised. Subnormal operands (exponent code 0) use the same rule. When such an operand rounds up into the normal range, its exponent becomes 1. An inexact flag reports that any of the three extra bits was set. The sign is not changed, so it does not appear at the outputs.

Top module: `fp_round_unit`

## Requirements
- R1: With `rnd_mode_i` = 00 (nearest, the default), the magnitude is incremented when the extra bits `{g,r,s}` = `xtra_i[2:0]` exceed one half (g=1 and r|s=1) and is left unchanged when g=0.
- R2: With mode 00 and extra bits exactly 100 (halfway), the result is the neighbour whose last kept bit is 0: it is unchanged if `sig_i[0]`=0 and incremented if `sig_i[0]`=1.
- R3: With mode 01 (toward zero), the extra bits are discarded: `frac_o` equals `sig_i[22:0]` and `exp_o` equals `exp_i`.
- R4: With mode 10 (toward +infinity), a positive value (`sign_i`=0) is incremented whenever any extra bit is set, and a negative value is left unchanged.
- R5: With mode 11 (toward -infinity), a negative value (`sign_i`=1) is incremented whenever any extra bit is set, and a positive value is left unchanged.
- R6: `inexact_o` is 1 exactly when any extra bit is nonzero. When it is 0, the outputs equal the input fraction and exponent in every mode.
- R7: If an increment carries out of the 24-bit significand, the result fraction is 0 and `exp_o` = `exp_i` + 1.
- R8: If that carry makes the exponent reach 255, the outputs are `exp_o` = 255, `frac_o` = 0 and `ovf_o` = 1. `ovf_o` is 0 in all other cases.
- R9: A subnormal input (`exp_i` = 0) is rounded by the same rule. If the increment sets the hidden bit, `exp_o` becomes 1. Otherwise `exp_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| exp_i | input | 8 | Biased exponent before rounding |
| sig_i | input | 24 | Significand including hidden bit at position 23 |
| xtra_i | input | 3 | Guard, round and sticky bits, guard at bit 2 |
| rnd_mode_i | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| frac_o | output | 23 | Rounded fraction field |
| exp_o | output | 8 | Adjusted exponent |
| inexact_o | output | 1 | Extra bits were nonzero |
| ovf_o | output | 1 | Rounding produced infinity |

## Verification
A wrong increment decision shows at once as a fraction off by exactly one unit in the last place, in the same evaluation as the input change. The halfway patterns for both parities and the sign-dependent directed modes separate one faulty mode from another. A bad carry path shows as a fraction of all ones or an unchanged exponent. A missed overflow leaves an exponent of 254, or 255 paired with a nonzero fraction. Each of these differs from the expected value on the first input pattern that reaches it.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_mode_e;

  localparam int unsigned GRS_W = 3;

endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  logic             sign_i,
  input  logic             lsb_i,
  input  logic [GRS_W-1:0] grs_i,
  input  logic [1:0]       mode_i,
  output logic             inc_o,
  output logic             any_o
);

  logic guard_b;
  logic tail_b;

  always_comb begin
    guard_b = grs_i[GRS_W-1];
    tail_b  = |grs_i[GRS_W-2:0];
    any_o   = |grs_i;
    unique case (rnd_mode_e'(mode_i))
      RND_NEAREST: inc_o = guard_b & (tail_b | lsb_i);
      RND_ZERO:    inc_o = 1'b0;
      RND_UP:      inc_o = any_o & ~sign_i;
      RND_DOWN:    inc_o = any_o & sign_i;
      default:     inc_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  input  logic             inc_i,
  output logic [MAN_W-1:0] frac_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             carry_o
);

  localparam int unsigned SIG_W = MAN_W + 1;

  logic [SIG_W:0]   sum_w;
  logic [SIG_W-1:0] norm_w;

  always_comb begin
    sum_w   = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_i};
    carry_o = sum_w[SIG_W];
    if (carry_o) begin
      norm_w = sum_w[SIG_W:1];
      exp_o  = exp_i + {{(EXP_W-1){1'b0}}, 1'b1};
    end else begin
      norm_w = sum_w[SIG_W-1:0];
      if ((exp_i == '0) && sum_w[SIG_W-1])
        exp_o = {{(EXP_W-1){1'b0}}, 1'b1};
      else
        exp_o = exp_i;
    end
    frac_o = norm_w[MAN_W-1:0];
  end

endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [MAN_W-1:0] frac_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             carry_i,
  output logic [MAN_W-1:0] frac_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             ovf_o
);

  localparam logic [EXP_W-1:0] EXP_INF = {EXP_W{1'b1}};

  always_comb begin
    ovf_o = carry_i && (exp_i == EXP_INF);
    if (ovf_o) begin
      frac_o = '0;
      exp_o  = EXP_INF;
    end else begin
      frac_o = frac_i;
      exp_o  = exp_i;
    end
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  input  logic [GRS_W-1:0] xtra_i,
  input  logic [1:0]       rnd_mode_i,
  output logic [MAN_W-1:0] frac_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             inexact_o,
  output logic             ovf_o
);

  logic             inc_w;
  logic             any_w;
  logic [MAN_W-1:0] frac_w;
  logic [EXP_W-1:0] exp_w;
  logic             carry_w;

  fp_round_decide u_decide (
    .sign_i (sign_i),
    .lsb_i  (sig_i[0]),
    .grs_i  (xtra_i),
    .mode_i (rnd_mode_i),
    .inc_o  (inc_w),
    .any_o  (any_w)
  );

  fp_round_incr #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_incr (
    .exp_i   (exp_i),
    .sig_i   (sig_i),
    .inc_i   (inc_w),
    .frac_o  (frac_w),
    .exp_o   (exp_w),
    .carry_o (carry_w)
  );

  fp_round_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .frac_i  (frac_w),
    .exp_i   (exp_w),
    .carry_i (carry_w),
    .frac_o  (frac_o),
    .exp_o   (exp_o),
    .ovf_o   (ovf_o)
  );

  assign inexact_o = any_w;

endmodule

// File: rtl/fp_round_chk.sv
module fp_round_chk #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input logic             sign_i,
  input logic [EXP_W-1:0] exp_i,
  input logic [MAN_W:0]   sig_i,
  input logic [2:0]       xtra_i,
  input logic [1:0]       rnd_mode_i,
  input logic [MAN_W-1:0] frac_o,
  input logic [EXP_W-1:0] exp_o,
  input logic             inexact_o,
  input logic             ovf_o
);

  logic unchanged_w;
  assign unchanged_w = (frac_o == sig_i[MAN_W-1:0]) && (exp_o == exp_i) && !ovf_o;

  always_comb begin
    // R3
    rtz_hold_chk: assert (rnd_mode_i != 2'b01 || unchanged_w);
    // R4
    up_neg_hold_chk: assert (!(rnd_mode_i == 2'b10 && sign_i) || unchanged_w);
    // R5
    down_pos_hold_chk: assert (!(rnd_mode_i == 2'b11 && !sign_i) || unchanged_w);
    // R6
    exact_pass_chk: assert (inexact_o || unchanged_w);
    // R7
    exp_step_chk: assert ((exp_o == exp_i) || (exp_o == exp_i + 1'b1));
    // R8
    ovf_inf_chk: assert (!ovf_o || ((exp_o == {EXP_W{1'b1}}) && (frac_o == '0) && inexact_o));
  end

endmodule

bind fp_round_unit fp_round_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .sign_i     (sign_i),
  .exp_i      (exp_i),
  .sig_i      (sig_i),
  .xtra_i     (xtra_i),
  .rnd_mode_i (rnd_mode_i),
  .frac_o     (frac_o),
  .exp_o      (exp_o),
  .inexact_o  (inexact_o),
  .ovf_o      (ovf_o)
);

// File: tb/fp_round_unit_test.sv
`timescale 1ns/1ps
module fp_round_unit_test;

  logic        clk;
  logic        rst_n;
  logic        sign_i;
  logic [7:0]  exp_i;
  logic [23:0] sig_i;
  logic [2:0]  xtra_i;
  logic [1:0]  rnd_mode_i;
  logic [22:0] frac_o;
  logic [7:0]  exp_o;
  logic        inexact_o;
  logic        ovf_o;

  int checks;
  int errors;

  fp_round_unit uut (
    .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i), .xtra_i(xtra_i),
    .rnd_mode_i(rnd_mode_i), .frac_o(frac_o), .exp_o(exp_o),
    .inexact_o(inexact_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic apply(input logic s, input logic [7:0] e, input logic [23:0] m,
                       input logic [2:0] x, input logic [1:0] md);
    @(negedge clk);
    sign_i = s; exp_i = e; sig_i = m; xtra_i = x; rnd_mode_i = md;
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [22:0] f, input logic [7:0] e,
                            input logic ix, input logic ov);
    checks++;
    if (frac_o !== f || exp_o !== e || inexact_o !== ix || ovf_o !== ov) begin
      errors++;
      $display("FAIL %s: got frac=%h exp=%h ix=%b ov=%b expected frac=%h exp=%h ix=%b ov=%b",
               tag, frac_o, exp_o, inexact_o, ovf_o, f, e, ix, ov);
    end
  endtask

  task automatic t_idle();
    apply(1'b0, 8'h00, 24'h000000, 3'b000, 2'b00);
    expect_out("R6 idle zero", 23'h0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_nearest();
    apply(1'b0, 8'h40, 24'h800001, 3'b011, 2'b00);
    expect_out("R1 below half", 23'h000001, 8'h40, 1'b1, 1'b0);
    apply(1'b1, 8'h40, 24'h800001, 3'b101, 2'b00);
    expect_out("R1 above half", 23'h000002, 8'h40, 1'b1, 1'b0);
  endtask

  task automatic t_ties();
    apply(1'b0, 8'h22, 24'h800002, 3'b100, 2'b00);
    expect_out("R2 tie even", 23'h000002, 8'h22, 1'b1, 1'b0);
    apply(1'b0, 8'h22, 24'h800003, 3'b100, 2'b00);
    expect_out("R2 tie odd", 23'h000004, 8'h22, 1'b1, 1'b0);
  endtask

  task automatic t_zero();
    apply(1'b0, 8'h7F, 24'h8FFFFF, 3'b111, 2'b01);
    expect_out("R3 truncate", 23'h0FFFFF, 8'h7F, 1'b1, 1'b0);
    apply(1'b0, 8'hFE, 24'hFFFFFF, 3'b111, 2'b01);
    expect_out("R3 truncate max", 23'h7FFFFF, 8'hFE, 1'b1, 1'b0);
  endtask

  task automatic t_up_down();
    apply(1'b0, 8'h10, 24'h800000, 3'b001, 2'b10);
    expect_out("R4 up positive", 23'h000001, 8'h10, 1'b1, 1'b0);
    apply(1'b1, 8'h10, 24'h800000, 3'b001, 2'b10);
    expect_out("R4 up negative", 23'h000000, 8'h10, 1'b1, 1'b0);
    apply(1'b1, 8'h10, 24'h800000, 3'b010, 2'b11);
    expect_out("R5 down negative", 23'h000001, 8'h10, 1'b1, 1'b0);
    apply(1'b0, 8'h10, 24'h800000, 3'b111, 2'b11);
    expect_out("R5 down positive", 23'h000000, 8'h10, 1'b1, 1'b0);
  endtask

  task automatic t_exact();
    apply(1'b0, 8'h33, 24'hABCDEF, 3'b000, 2'b10);
    expect_out("R6 exact up", 23'h2BCDEF, 8'h33, 1'b0, 1'b0);
    apply(1'b1, 8'h33, 24'hFFFFFF, 3'b000, 2'b11);
    expect_out("R6 exact down", 23'h7FFFFF, 8'h33, 1'b0, 1'b0);
  endtask

  task automatic t_carry();
    apply(1'b0, 8'h10, 24'hFFFFFF, 3'b110, 2'b00);
    expect_out("R7 carry renorm", 23'h000000, 8'h11, 1'b1, 1'b0);
    apply(1'b1, 8'hFD, 24'hFFFFFF, 3'b001, 2'b11);
    expect_out("R7 carry to 254", 23'h000000, 8'hFE, 1'b1, 1'b0);
  endtask

  task automatic t_ovf();
    apply(1'b0, 8'hFE, 24'hFFFFFF, 3'b001, 2'b10);
    expect_out("R8 overflow up", 23'h000000, 8'hFF, 1'b1, 1'b1);
    apply(1'b1, 8'hFE, 24'hFFFFFF, 3'b100, 2'b00);
    expect_out("R8 overflow nearest", 23'h000000, 8'hFF, 1'b1, 1'b1);
    apply(1'b1, 8'hFE, 24'hFFFFFF, 3'b100, 2'b10);
    expect_out("R8 no overflow", 23'h7FFFFF, 8'hFE, 1'b1, 1'b0);
  endtask

  task automatic t_subnormal();
    apply(1'b0, 8'h00, 24'h7FFFFF, 3'b100, 2'b00);
    expect_out("R9 subnormal to normal", 23'h000000, 8'h01, 1'b1, 1'b0);
    apply(1'b0, 8'h00, 24'h000010, 3'b110, 2'b00);
    expect_out("R9 subnormal stays", 23'h000011, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    sign_i = 1'b0; exp_i = '0; sig_i = '0; xtra_i = '0; rnd_mode_i = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_nearest();
    t_ties();
    t_zero();
    t_up_down();
    t_exact();
    t_carry();
    t_ovf();
    t_subnormal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule